// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar in packed BCD registers. A one-cycle pulse from an external 1 Hz prescaler, `sec_tick`, advances the seconds. A carry then ripples through minutes, hours, date, month and year, and the day-of-week field steps once per day. The hours byte is stored in either a 24-hour or a 12-hour encoding with a PM flag. The last day of each month is computed from the month and year, and February gets 29 days in every year whose two-digit value is a multiple of four.

A host reaches every register through a simple index port. Writes take effect on the next clock edge. Reads are combinational from the index. A write-protect bit in the control register blocks host writes to every other register. A century register is held for the host and is never advanced by the counters. A host write to seconds raises `phase_clr` for one cycle, so that the external prescaler restarts its sub-second phase.

Top module: `calclk_core`

## Requirements
- R1: Seconds (index 0) and minutes (index 1) hold BCD (tens in bits 7:4, units in bits 3:0), count 00 to 59 and wrap to 00. Each wrap advances the next field once.
- R2: With hours (index 2) bit 7 clear, hours count 00 to 23 in BCD in bits 5:0. The change from 23 to 00 advances the date and the day of week.
- R3: With hours bit 7 set, bit 5 is PM (1 = PM), bit 4 is the tens digit and bits 3:0 are the units, with a range of 01 to 12. The sequence runs 11 AM to 12 PM to 01 PM, and 11 PM to 12 AM. Only the change from 11 PM to 12 AM advances the date.
- R4: Date (index 3) counts from 01 up to the last day of the month: 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all others. The next day carry returns it to 01 and advances the month.
- R5: February has 29 days when the year value is a multiple of 4 (00 included), and 28 days otherwise.
- R6: Month (index 4) counts 01 to 12. Its wrap advances the year (index 6), which counts 00 to 99. The century (index 8) never changes except by a host write.
- R7: Day of week (index 5) counts 01 to 07 and returns to 01 on the day carry after 07.
- R8: After reset, the registers read: seconds 00, minutes 00, hours 00 (24-hour mode), date 01, month 01, day 01, year 70, control 00, century 19.
- R9: Control (index 7) stores only bit 7, the write-protect bit, and bits 6:0 read 0. While that bit is set, host writes to every index except 7 are ignored. The control register itself stays writable.
- R10: An accepted host write to seconds drives `phase_clr` high for exactly the following cycle. A blocked write does not raise it.
- R11: `host_rdata` returns the register at `host_addr` in the same cycle, and indices 9 to 15 read 00. A tick that arrives in the same cycle as an accepted host write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Register index for read and write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by host_addr |
| phase_clr | output | 1 | Pulse that restarts the external prescaler phase |

## Verification
A wrong carry or wrap limit in any field shows at the ports on the first tick that crosses that boundary. A bad wrap shows a non-BCD or out-of-range value in the field itself. A bad carry shows a missing or extra step in the field above it, at the next read. For this reason the bench presets each field just below its limit and reads the whole register set after a single tick. A wrong write-protect or tick-discard decision shows at the next read of the targeted field or of seconds. A wrong prescaler-restart decision shows on `phase_clr` one cycle after the write.

// File: rtl/calclk_pkg.sv
package calclk_pkg;
  localparam int NUM_REGS  = 9;
  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_DATE  = 3;
  localparam int IDX_MONTH = 4;
  localparam int IDX_DOW   = 5;
  localparam int IDX_YEAR  = 6;
  localparam int IDX_CTRL  = 7;
  localparam int IDX_CENT  = 8;

  typedef logic [7:0] bcd8_t;

  // Add one to a two-digit packed BCD value
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/calclk_rst_sync.sv
module calclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/calclk_bcd_field.sv
module calclk_bcd_field
  import calclk_pkg::*;
#(
  parameter bcd8_t RST_VAL = 8'h00,
  parameter bcd8_t WMASK   = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_en,
  input  bcd8_t lo,
  input  bcd8_t hi,
  input  logic  ld_en,
  input  bcd8_t ld_val,
  output bcd8_t q,
  output logic  wrap
);
  bcd8_t q_nxt;
  logic  at_top;

  always_comb begin
    at_top = (q >= hi);
    wrap   = inc_en && at_top;
    q_nxt  = q;
    if (ld_en)       q_nxt = ld_val & WMASK;
    else if (inc_en) q_nxt = at_top ? lo : bcd_inc(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= RST_VAL;
    else if (ld_en || inc_en)  q <= q_nxt;
  end
endmodule

// File: rtl/calclk_hour_field.sv
module calclk_hour_field
  import calclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_en,
  input  logic  ld_en,
  input  bcd8_t ld_val,
  output bcd8_t q,
  output logic  day_carry
);
  bcd8_t q_nxt;
  logic  wrap_day;
  bcd8_t h12_inc;
  bcd8_t h24_inc;

  always_comb begin
    h12_inc  = bcd_inc({3'b000, q[4:0]});
    h24_inc  = bcd_inc({2'b00, q[5:0]});
    wrap_day = 1'b0;
    q_nxt    = q;
    if (q[7]) begin
      // 12-hour encoding: bit 5 PM, bits 4:0 hour 01..12
      if (q[4:0] == 5'h11) begin
        q_nxt    = {1'b1, 1'b0, ~q[5], 5'h12};
        wrap_day = q[5];
      end else if (q[4:0] >= 5'h12) begin
        q_nxt = {1'b1, 1'b0, q[5], 5'h01};
      end else begin
        q_nxt = {1'b1, 1'b0, q[5], h12_inc[4:0]};
      end
    end else begin
      if (q[5:0] >= 6'h23) begin
        q_nxt    = 8'h00;
        wrap_day = 1'b1;
      end else begin
        q_nxt = {2'b00, h24_inc[5:0]};
      end
    end
    if (ld_en) q_nxt = ld_val & (ld_val[7] ? 8'hBF : 8'h3F);
    day_carry = inc_en && !ld_en && wrap_day;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= 8'h00;
    else if (ld_en || inc_en) q <= q_nxt;
  end
endmodule

// File: rtl/calclk_month_len.sv
module calclk_month_len
  import calclk_pkg::*;
(
  input  bcd8_t month,
  input  bcd8_t year,
  output bcd8_t last_day
);
  logic [1:0] yr_mod4;
  logic       leap;

  // (10*tens + units) mod 4 == (2*tens + units) mod 4
  assign yr_mod4 = {year[4], 1'b0} + year[1:0];
  assign leap    = (yr_mod4 == 2'd0);

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/calclk_core.sv
module calclk_core
  import calclk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              phase_clr
);
  localparam int NUM_IDX = 2 ** ADDR_W;

  logic rst_sync_n;
  logic [NUM_REGS-1:0] wr_sel;
  logic wr_any;
  logic tick_ok;
  logic wp_q;
  bcd8_t sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q, cent_q, ctrl_q;
  bcd8_t last_day;
  logic sec_wrap, min_wrap, day_carry, date_wrap, month_wrap;
  logic dow_wrap, year_wrap, cent_wrap;
  bcd8_t regv [NUM_IDX];

  calclk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Write decode: control always writable, others gated by write protect
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel[i] = host_we && (host_addr == ADDR_W'(i)) &&
                       ((i == IDX_CTRL) || !wp_q);
  end
  assign wr_any  = |wr_sel;
  assign tick_ok = sec_tick && !wr_any;

  calclk_bcd_field #(.RST_VAL(8'h00), .WMASK(8'h7F)) u_sec (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(tick_ok), .lo(8'h00), .hi(8'h59),
    .ld_en(wr_sel[IDX_SEC]), .ld_val(host_wdata), .q(sec_q), .wrap(sec_wrap));

  calclk_bcd_field #(.RST_VAL(8'h00), .WMASK(8'h7F)) u_min (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(sec_wrap), .lo(8'h00), .hi(8'h59),
    .ld_en(wr_sel[IDX_MIN]), .ld_val(host_wdata), .q(min_q), .wrap(min_wrap));

  calclk_hour_field u_hour (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(min_wrap),
    .ld_en(wr_sel[IDX_HOUR]), .ld_val(host_wdata), .q(hour_q),
    .day_carry(day_carry));

  calclk_month_len u_mlen (.month(month_q), .year(year_q), .last_day(last_day));

  calclk_bcd_field #(.RST_VAL(8'h01), .WMASK(8'h3F)) u_date (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(day_carry), .lo(8'h01), .hi(last_day),
    .ld_en(wr_sel[IDX_DATE]), .ld_val(host_wdata), .q(date_q), .wrap(date_wrap));

  calclk_bcd_field #(.RST_VAL(8'h01), .WMASK(8'h1F)) u_month (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(date_wrap), .lo(8'h01), .hi(8'h12),
    .ld_en(wr_sel[IDX_MONTH]), .ld_val(host_wdata), .q(month_q), .wrap(month_wrap));

  calclk_bcd_field #(.RST_VAL(8'h01), .WMASK(8'h07)) u_dow (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(day_carry), .lo(8'h01), .hi(8'h07),
    .ld_en(wr_sel[IDX_DOW]), .ld_val(host_wdata), .q(dow_q), .wrap(dow_wrap));

  calclk_bcd_field #(.RST_VAL(8'h70), .WMASK(8'hFF)) u_year (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(month_wrap), .lo(8'h00), .hi(8'h99),
    .ld_en(wr_sel[IDX_YEAR]), .ld_val(host_wdata), .q(year_q), .wrap(year_wrap));

  // Century: host-loaded only, never advanced
  calclk_bcd_field #(.RST_VAL(8'h19), .WMASK(8'hFF)) u_cent (
    .clk(clk), .rst_n(rst_sync_n), .inc_en(1'b0), .lo(8'h00), .hi(8'h99),
    .ld_en(wr_sel[IDX_CENT]), .ld_val(host_wdata), .q(cent_q), .wrap(cent_wrap));

  // Control: only the write-protect bit is stored
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           wp_q <= 1'b0;
    else if (wr_sel[IDX_CTRL]) wp_q <= host_wdata[7];
  end
  assign ctrl_q = {wp_q, 7'd0};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) phase_clr <= 1'b0;
    else             phase_clr <= wr_sel[IDX_SEC];
  end

  // Read map
  for (genvar j = 0; j < NUM_IDX; j++) begin : g_rmap
    if      (j == IDX_SEC)   begin : g_s assign regv[j] = sec_q;   end
    else if (j == IDX_MIN)   begin : g_m assign regv[j] = min_q;   end
    else if (j == IDX_HOUR)  begin : g_h assign regv[j] = hour_q;  end
    else if (j == IDX_DATE)  begin : g_d assign regv[j] = date_q;  end
    else if (j == IDX_MONTH) begin : g_o assign regv[j] = month_q; end
    else if (j == IDX_DOW)   begin : g_w assign regv[j] = dow_q;   end
    else if (j == IDX_YEAR)  begin : g_y assign regv[j] = year_q;  end
    else if (j == IDX_CTRL)  begin : g_c assign regv[j] = ctrl_q;  end
    else if (j == IDX_CENT)  begin : g_t assign regv[j] = cent_q;  end
    else                     begin : g_z assign regv[j] = 8'h00;   end
  end
  assign host_rdata = regv[host_addr];
endmodule

// File: rtl/calclk_checker.sv
module calclk_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        sec_q,
  input logic [7:0]        year_q,
  input logic [7:0]        cent_q,
  input logic [7:0]        ctrl_q,
  input logic              phase_clr
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !host_we && sec_q == 8'h59) |=> (sec_q == 8'h00)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !host_we) |=> ($stable(sec_q) && $stable(year_q))); // R11

  AST_CENT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == ADDR_W'(8)) |=> $stable(cent_q)); // R6

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6:0] == 7'd0); // R9

  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && ctrl_q[7] && !sec_tick && host_addr == ADDR_W'(6))
      |=> $stable(year_q)); // R9

  AST_PHASE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |-> $past(host_we && host_addr == ADDR_W'(0) && !ctrl_q[7])); // R10
endmodule

bind calclk_core calclk_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sec_tick(sec_tick), .host_we(host_we),
  .host_addr(host_addr), .sec_q(sec_q), .year_q(year_q), .cent_q(cent_q),
  .ctrl_q(ctrl_q), .phase_clr(phase_clr));

// File: tb/calclk_core_bench.sv
module calclk_core_bench;
  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic       host_we;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       phase_clr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  calclk_core u_calclk_core (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phase_clr(phase_clr));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    rdchk("R8 sec", 0, 8'h00);  rdchk("R8 min", 1, 8'h00);
    rdchk("R8 hour", 2, 8'h00); rdchk("R8 date", 3, 8'h01);
    rdchk("R8 month", 4, 8'h01); rdchk("R8 dow", 5, 8'h01);
    rdchk("R8 year", 6, 8'h70); rdchk("R8 ctrl", 7, 8'h00);
    rdchk("R8 cent", 8, 8'h19);
    rdchk("R11 unused 9", 9, 8'h00); rdchk("R11 unused 15", 15, 8'h00);
    chk("R10 phase idle", {7'd0, phase_clr}, 8'h00);
  endtask

  task automatic t_full_roll();
    wr(0, 8'h58); wr(1, 8'h59); wr(2, 8'h23); wr(3, 8'h31);
    wr(4, 8'h12); wr(5, 8'h07); wr(6, 8'h99); wr(8, 8'h20);
    tick();
    rdchk("R1 sec 58->59", 0, 8'h59);
    rdchk("R1 min held", 1, 8'h59);
    tick();
    rdchk("R1 sec wrap", 0, 8'h00);   rdchk("R1 min wrap", 1, 8'h00);
    rdchk("R2 hour 23->00", 2, 8'h00); rdchk("R4 date 31->01", 3, 8'h01);
    rdchk("R6 month 12->01", 4, 8'h01); rdchk("R7 dow 07->01", 5, 8'h01);
    rdchk("R6 year 99->00", 6, 8'h00); rdchk("R6 century fixed", 8, 8'h20);
  endtask

  task automatic to_hour_end(input logic [7:0] hr);
    wr(2, hr); wr(1, 8'h59); wr(0, 8'h59);
    tick();
  endtask

  task automatic t_12h();
    wr(3, 8'h05); wr(5, 8'h03);
    to_hour_end(8'h91);
    rdchk("R3 11AM->12PM", 2, 8'hB2);
    rdchk("R3 no date step at noon", 3, 8'h05);
    to_hour_end(8'hB2);
    rdchk("R3 12PM->01PM", 2, 8'hA1);
    to_hour_end(8'hB1);
    rdchk("R3 11PM->12AM", 2, 8'h92);
    rdchk("R3 date step at midnight", 3, 8'h06);
    rdchk("R7 dow step", 5, 8'h04);
    to_hour_end(8'h89);
    rdchk("R3 09AM->10AM", 2, 8'h90);
  endtask

  task automatic mlen(input string tag, input logic [7:0] y, input logic [7:0] m,
                      input logic [7:0] d, input logic [7:0] em, input logic [7:0] ed);
    wr(6, y); wr(4, m); wr(3, d);
    to_hour_end(8'h23);
    rdchk({tag, " month"}, 4, em);
    rdchk({tag, " date"}, 3, ed);
  endtask

  task automatic t_month_len();
    mlen("R5 feb28 yr23", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    mlen("R5 feb28 yr24", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    mlen("R5 feb29 yr24", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    mlen("R5 feb28 yr00", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    mlen("R5 feb28 yr10", 8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
    mlen("R4 apr30", 8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    mlen("R4 sep30", 8'h25, 8'h09, 8'h30, 8'h10, 8'h01);
    mlen("R4 jan30", 8'h25, 8'h01, 8'h30, 8'h01, 8'h31);
    mlen("R4 nov29", 8'h25, 8'h11, 8'h29, 8'h11, 8'h30);
  endtask

  task automatic t_wp();
    wr(6, 8'h40);
    wr(7, 8'hFF);
    rdchk("R9 ctrl only bit7", 7, 8'h80);
    wr(6, 8'h55);
    rdchk("R9 year write blocked", 6, 8'h40);
    wr(8, 8'h21);
    rdchk("R9 century write blocked", 8, 8'h20);
    @(negedge clk);
    host_we = 1'b1; host_addr = 0; host_wdata = 8'h33;
    @(negedge clk);
    host_we = 1'b0;
    chk("R10 no pulse when blocked", {7'd0, phase_clr}, 8'h00);
    rdchk("R9 sec write blocked", 0, 8'h00);
    wr(7, 8'h00);
    rdchk("R9 ctrl cleared", 7, 8'h00);
    wr(6, 8'h55);
    rdchk("R9 year write accepted", 6, 8'h55);
  endtask

  task automatic t_phase();
    wr(0, 8'h30);
    chk("R10 pulse after sec write", {7'd0, phase_clr}, 8'h01);
    @(negedge clk);
    chk("R10 pulse one cycle", {7'd0, phase_clr}, 8'h00);
    wr(1, 8'h12);
    chk("R10 no pulse on min write", {7'd0, phase_clr}, 8'h00);
  endtask

  task automatic t_collide();
    wr(0, 8'h10);
    @(negedge clk);
    host_we = 1'b1; host_addr = 1; host_wdata = 8'h20; sec_tick = 1'b1;
    @(negedge clk);
    host_we = 1'b0; sec_tick = 1'b0;
    rdchk("R11 tick dropped on write", 0, 8'h10);
    rdchk("R11 write landed", 1, 8'h20);
    tick();
    rdchk("R1 tick after collide", 0, 8'h11);
  endtask

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; host_we = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_roll();
    t_12h();
    t_month_len();
    t_wp();
    t_phase();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule